// File: doc/BRIEF.md
# Hardware Breakpoint Trigger Unit

This block watches a processor's bus address, bus data and program counter and raises a debug request when programmed conditions match. Nine 32-bit comparison registers are available: an address value and its mask, a data value and its mask, four program-counter values, and a single program-counter mask that is shared by all four. A control register chooses which conditions form each trigger level and whether triggering takes one step or two. It also chooses whether a firing trigger requests a processor halt or a debug interrupt.

A simple synchronous write port with a combinational read port loads and inspects all registers. This port stands in for a debug serial channel or supervisor access. In two-level mode the first-level condition arms the unit and a later second-level condition fires it. After firing, the unit stays disabled until software writes the control register again.

Top module: `bkpt_trigger`

## Requirements
- R1: Register indices are 0 address, 1 address mask, 2 data, 3 data mask, 4 to 7 program counters 0 to 3, 8 program-counter mask and 9 control. A write with `cfg_we` high stores `cfg_wdata` at the next edge. `cfg_rdata` shows the indexed register combinationally, and any index above 9 reads 0. After reset every register reads 0.
- R2: The address condition holds when `bus_addr_vld` is high and every address bit whose mask bit is 0 equals the programmed bit. Bits whose mask bit is 1 are ignored.
- R3: The data condition uses the same masked rule with the data registers. It holds only in cycles where `bus_data_vld` is high.
- R4: The program-counter condition holds when `pc_vld` is high and any of the four program-counter registers matches `pc` under the shared program-counter mask.
- R5: Control bits [3:1] select the first-level conditions and bits [6:4] select the second-level conditions. Within each field, bit 0 is address, bit 1 is data and bit 2 is program counter. A level is met only when all of its selected conditions hold in the same cycle. A level with no conditions selected is never met.
- R6: Control bit 0 enables the unit. With control bit 7 at 0, a first-level hit while enabled fires the unit, and the output pulse appears in the next cycle.
- R7: With control bit 7 at 1, a first-level hit arms the unit. The unit fires only on a second-level hit in a later cycle while armed. A second-level hit before arming, or in the same cycle as arming, does nothing. The armed state reads back as bit 9 of the control register.
- R8: Control bit 8 selects the action: 0 pulses `halt_req` and 1 pulses `dbg_irq`. The two are never high together.
- R9: Each request is a one-cycle pulse. Firing clears the enable bit and the armed state, so further matches do nothing until the control register is written again. Control bit 0 reads 0 after a fire.
- R10: Writing the control register clears the armed state. No request fires in a cycle that writes the control register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_idx | input | 4 | Register index |
| cfg_wdata | input | 32 | Write data |
| cfg_rdata | output | 32 | Read data for `cfg_idx` |
| bus_addr_vld | input | 1 | Bus address is valid |
| bus_addr | input | 32 | Bus address |
| bus_data_vld | input | 1 | Bus data is valid |
| bus_data | input | 32 | Bus data |
| pc_vld | input | 1 | Program counter is valid |
| pc | input | 32 | Program counter |
| halt_req | output | 1 | One-cycle halt request |
| dbg_irq | output | 1 | One-cycle debug interrupt request |

## Verification
A match presented in cycle N produces its request pulse on the registered outputs right after edge N. The bench therefore drives each probe at a falling edge and samples the outputs 1 ns after the next rising edge. Register writes take effect at the edge that samples `cfg_we`, so every probe starts one full cycle after its setup writes. Read-back values, including the enable and armed bits, are combinational and are sampled 1 ns after the index is set. Two-level sequences are stepped one cycle at a time, so the bench can tell a fire in the arming cycle apart from a fire in the cycle after it.

// File: rtl/bkpt_trigger.sv
module bkpt_trigger #(
  parameter int W   = 32,
  parameter int NPC = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cfg_we,
  input  logic [3:0]   cfg_idx,
  input  logic [W-1:0] cfg_wdata,
  output logic [W-1:0] cfg_rdata,
  input  logic         bus_addr_vld,
  input  logic [W-1:0] bus_addr,
  input  logic         bus_data_vld,
  input  logic [W-1:0] bus_data,
  input  logic         pc_vld,
  input  logic [W-1:0] pc,
  output logic         halt_req,
  output logic         dbg_irq
);
  localparam int IDX_PC0  = 4;
  localparam int IDX_PCM  = IDX_PC0 + NPC;
  localparam int IDX_CTL  = IDX_PCM + 1;
  localparam int CW       = 9;

  logic [W-1:0] a_q, am_q, d_q, dm_q, pcm_q;
  logic [W-1:0] pc_q [NPC];
  logic [CW-1:0] ctl_q;
  logic armed;

  logic en, two, act;
  logic [2:0] sel1, sel2;
  assign en   = ctl_q[0];
  assign sel1 = ctl_q[3:1];
  assign sel2 = ctl_q[6:4];
  assign two  = ctl_q[7];
  assign act  = ctl_q[8];

  logic ctl_wr;
  assign ctl_wr = cfg_we && (int'(cfg_idx) == IDX_CTL);

  logic a_hit, d_hit, p_hit;
  logic [NPC-1:0] pc_m;
  assign a_hit = bus_addr_vld && (((bus_addr ^ a_q) & ~am_q) == '0);
  assign d_hit = bus_data_vld && (((bus_data ^ d_q) & ~dm_q) == '0);

  for (genvar i = 0; i < NPC; i++) begin : g_pc
    assign pc_m[i] = (((pc ^ pc_q[i]) & ~pcm_q) == '0);
  end
  assign p_hit = pc_vld && (|pc_m);

  function automatic logic lvl(input logic [2:0] s, input logic ah, input logic dh, input logic ph);
    return (s != 3'b000) && (!s[0] || ah) && (!s[1] || dh) && (!s[2] || ph);
  endfunction

  logic hit1, hit2, fire, arm;
  assign hit1 = lvl(sel1, a_hit, d_hit, p_hit);
  assign hit2 = lvl(sel2, a_hit, d_hit, p_hit);
  assign fire = en && !ctl_wr && (two ? (armed && hit2) : hit1);
  assign arm  = en && !ctl_wr && two && !armed && hit1;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      a_q <= '0; am_q <= '0; d_q <= '0; dm_q <= '0; pcm_q <= '0;
      for (int i = 0; i < NPC; i++) pc_q[i] <= '0;
    end else if (cfg_we) begin
      if (cfg_idx == 4'd0) a_q  <= cfg_wdata;
      if (cfg_idx == 4'd1) am_q <= cfg_wdata;
      if (cfg_idx == 4'd2) d_q  <= cfg_wdata;
      if (cfg_idx == 4'd3) dm_q <= cfg_wdata;
      if (int'(cfg_idx) == IDX_PCM) pcm_q <= cfg_wdata;
      for (int i = 0; i < NPC; i++)
        if (int'(cfg_idx) == IDX_PC0 + i) pc_q[i] <= cfg_wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctl_q    <= '0;
      armed    <= 1'b0;
      halt_req <= 1'b0;
      dbg_irq  <= 1'b0;
    end else begin
      halt_req <= fire && !act;
      dbg_irq  <= fire && act;
      if (ctl_wr) begin
        ctl_q <= cfg_wdata[CW-1:0];
        armed <= 1'b0;
      end else if (fire) begin
        ctl_q[0] <= 1'b0;
        armed    <= 1'b0;
      end else if (arm) begin
        armed <= 1'b1;
      end
    end
  end

  always_comb begin
    cfg_rdata = '0;
    case (int'(cfg_idx))
      0: cfg_rdata = a_q;
      1: cfg_rdata = am_q;
      2: cfg_rdata = d_q;
      3: cfg_rdata = dm_q;
      IDX_PCM: cfg_rdata = pcm_q;
      IDX_CTL: cfg_rdata = W'({armed, ctl_q});
      default: begin
        for (int i = 0; i < NPC; i++)
          if (int'(cfg_idx) == IDX_PC0 + i) cfg_rdata = pc_q[i];
      end
    endcase
  end
endmodule

// File: rtl/bkpt_trigger_chk.sv
module bkpt_trigger_chk (
  input logic clk,
  input logic rst_n,
  input logic ctl_wr,
  input logic en,
  input logic two,
  input logic armed,
  input logic halt_req,
  input logic dbg_irq
);
  a_r8_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(halt_req && dbg_irq));

  a_r9_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    (halt_req || dbg_irq) |=> !(halt_req || dbg_irq));

  a_r9_disarm: assert property (@(posedge clk) disable iff (!rst_n)
    (halt_req || dbg_irq) |-> (!en && !armed));

  a_r10_ctl_clears_arm: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_wr |=> (!armed && !halt_req && !dbg_irq));

  a_r7_fire_needs_arm: assert property (@(posedge clk) disable iff (!rst_n)
    ((halt_req || dbg_irq) && two) |-> $past(armed));
endmodule

bind bkpt_trigger bkpt_trigger_chk u_chk (
  .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .en(en), .two(two),
  .armed(armed), .halt_req(halt_req), .dbg_irq(dbg_irq)
);

// File: tb/sim_bkpt_trigger.sv
module sim_bkpt_trigger;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_we = 1'b0;
  logic [3:0] cfg_idx = '0;
  logic [31:0] cfg_wdata = '0, cfg_rdata;
  logic bus_addr_vld = 1'b0, bus_data_vld = 1'b0, pc_vld = 1'b0;
  logic [31:0] bus_addr = '0, bus_data = '0, pc = '0;
  logic halt_req, dbg_irq;
  int errors = 0, checks = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  bkpt_trigger u0 (.*);

  function automatic logic [31:0] cw(bit en, bit [2:0] s1, bit [2:0] s2, bit two, bit act);
    return {23'd0, act, two, s2, s1, en};
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(int idx, logic [31:0] v);
    @(negedge clk);
    cfg_we = 1'b1; cfg_idx = 4'(idx); cfg_wdata = v;
    @(posedge clk);
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic rd(string req, int idx, logic [31:0] exp);
    @(negedge clk);
    cfg_idx = 4'(idx);
    #1 chk(req, cfg_rdata, exp);
  endtask

  task automatic probe(string req, bit av, logic [31:0] a, bit dv, logic [31:0] d,
                       bit pv, logic [31:0] p, bit eh, bit ei);
    @(negedge clk);
    bus_addr_vld = av; bus_addr = a; bus_data_vld = dv; bus_data = d; pc_vld = pv; pc = p;
    @(posedge clk);
    #1;
    chk(req, {30'd0, halt_req, dbg_irq}, {30'd0, eh, ei});
    @(negedge clk);
    bus_addr_vld = 0; bus_data_vld = 0; pc_vld = 0;
  endtask

  initial begin
    #400000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    #1 chk("R1 reset outputs", {30'd0, halt_req, dbg_irq}, 32'd0);
    for (int i = 0; i < 11; i++) rd("R1 reset read", i, 32'd0);

    // R1 readback of every register, unused index reads 0
    for (int i = 0; i < 9; i++) wr(i, 32'h1357_0000 + 32'(i) * 32'h0101_0101);
    for (int i = 0; i < 9; i++) rd("R1 readback", i, 32'h1357_0000 + 32'(i) * 32'h0101_0101);
    wr(9, cw(0, 3'b101, 3'b010, 1, 1));
    rd("R1 ctl readback", 9, cw(0, 3'b101, 3'b010, 1, 1));
    wr(12, 32'hFFFF_FFFF);
    rd("R1 unused index", 12, 32'd0);

    // R2 address mask sweep, single-level halt
    wr(0, 32'hA5C3_0F96);
    for (int b = 0; b < 32; b++) begin
      for (int m = 0; m < 2; m++) begin
        wr(1, m ? (32'd1 << b) : 32'd0);
        wr(9, cw(1, 3'b001, 3'b000, 0, 0));
        probe("R2 addr bit", 1, 32'hA5C3_0F96 ^ (32'd1 << b), 0, 0, 0, 0, bit'(m), 0);
      end
    end
    wr(1, 32'd0);
    wr(9, cw(1, 3'b001, 3'b000, 0, 0));
    probe("R2 addr not valid", 0, 32'hA5C3_0F96, 0, 0, 0, 0, 0, 0);
    probe("R2 addr exact", 1, 32'hA5C3_0F96, 0, 0, 0, 0, 1, 0);

    // R3 data compare gated by valid, mask sweep
    wr(2, 32'h0BAD_F00D);
    for (int b = 0; b < 32; b += 3) begin
      wr(3, 32'd1 << b);
      wr(9, cw(1, 3'b010, 3'b000, 0, 0));
      probe("R3 data masked bit", 0, 0, 1, 32'h0BAD_F00D ^ (32'd1 << b), 0, 0, 1, 0);
      wr(9, cw(1, 3'b010, 3'b000, 0, 0));
      probe("R3 data unmasked bit", 0, 0, 1, 32'h0BAD_F00D ^ (32'd2 << b), 0, 0, 0, 0);
    end
    wr(3, 32'd0);
    wr(9, cw(1, 3'b010, 3'b000, 0, 0));
    probe("R3 data no valid", 0, 0, 0, 32'h0BAD_F00D, 0, 0, 0, 0);
    probe("R3 data valid", 0, 0, 1, 32'h0BAD_F00D, 0, 0, 1, 0);

    // R4 four program counters with shared mask
    for (int i = 0; i < 4; i++) wr(4 + i, 32'h0000_1000 * 32'(i + 1));
    wr(8, 32'h0000_000F);
    for (int i = 0; i < 4; i++) begin
      wr(9, cw(1, 3'b100, 3'b000, 0, 0));
      probe("R4 pc hit", 0, 0, 0, 0, 1, 32'h0000_1000 * 32'(i + 1) + 32'(i * 3), 1, 0);
      wr(9, cw(1, 3'b100, 3'b000, 0, 0));
      probe("R4 pc miss", 0, 0, 0, 0, 1, 32'h0000_1010 * 32'(i + 1), 0, 0);
    end
    probe("R4 pc no valid", 0, 0, 0, 0, 0, 32'h0000_1000, 0, 0);

    // R5 AND of selected conditions; empty select never fires
    wr(9, cw(1, 3'b011, 3'b000, 0, 0));
    probe("R5 addr only", 1, 32'hA5C3_0F96, 0, 0, 0, 0, 0, 0);
    probe("R5 data only", 0, 0, 1, 32'h0BAD_F00D, 0, 0, 0, 0);
    probe("R5 both", 1, 32'hA5C3_0F96, 1, 32'h0BAD_F00D, 0, 0, 1, 0);
    wr(9, cw(1, 3'b000, 3'b000, 0, 0));
    probe("R5 empty select", 1, 32'hA5C3_0F96, 1, 32'h0BAD_F00D, 1, 32'h1000, 0, 0);

    // R6 disabled unit ignores matches
    wr(9, cw(0, 3'b001, 3'b000, 0, 0));
    probe("R6 disabled", 1, 32'hA5C3_0F96, 0, 0, 0, 0, 0, 0);

    // R8 interrupt action, R9 disarm after fire
    wr(9, cw(1, 3'b001, 3'b000, 0, 1));
    probe("R8 irq action", 1, 32'hA5C3_0F96, 0, 0, 0, 0, 0, 1);
    probe("R9 no second pulse", 1, 32'hA5C3_0F96, 0, 0, 0, 0, 0, 0);
    rd("R9 enable cleared", 9, cw(0, 3'b001, 3'b000, 0, 1));

    // R7 two-level: level1 pc, level2 address
    wr(9, cw(1, 3'b100, 3'b001, 1, 0));
    probe("R7 level2 before arm", 1, 32'hA5C3_0F96, 0, 0, 0, 0, 0, 0);
    probe("R7 arm with level2 same cycle", 1, 32'hA5C3_0F96, 0, 0, 1, 32'h1000, 0, 0);
    rd("R7 armed reads back", 9, 32'h200 | cw(1, 3'b100, 3'b001, 1, 0));
    probe("R7 idle while armed", 0, 0, 0, 0, 0, 0, 0, 0);
    probe("R7 level2 fires", 1, 32'hA5C3_0F96, 0, 0, 0, 0, 1, 0);
    rd("R9 armed and enable cleared", 9, cw(0, 3'b100, 3'b001, 1, 0));

    // R10 control write clears the armed state
    wr(9, cw(1, 3'b100, 3'b001, 1, 1));
    probe("R10 arm", 0, 0, 0, 0, 1, 32'h2000, 0, 0);
    wr(9, cw(1, 3'b100, 3'b001, 1, 1));
    rd("R10 armed cleared", 9, cw(1, 3'b100, 3'b001, 1, 1));
    probe("R10 no fire after rewrite", 1, 32'hA5C3_0F96, 0, 0, 0, 0, 0, 0);

    // R10 no fire in a control-write cycle
    wr(9, cw(1, 3'b001, 3'b000, 0, 0));
    @(negedge clk);
    bus_addr_vld = 1; bus_addr = 32'hA5C3_0F96;
    cfg_we = 1; cfg_idx = 4'd9; cfg_wdata = cw(1, 3'b001, 3'b000, 0, 0);
    @(posedge clk); #1;
    chk("R10 write cycle suppressed", {31'd0, halt_req}, 32'd0);
    @(negedge clk);
    cfg_we = 0;
    @(posedge clk); #1;
    chk("R10 fires after write cycle", {31'd0, halt_req}, 32'd1);
    @(negedge clk);
    bus_addr_vld = 0;

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule